// File: doc/BRIEF.md
# Superscalar Dispatch Gate with Carry-Over

This block sits between an in-order decode queue and the scheduler. It decides, every clock cycle, whether the queue's head instruction may be dispatched. Each instruction states three demands: a micro-op count, a count of destination registers to rename, and a number of scheduler-buffer entries. The block compares those demands with the free-entry counts reported by the reorder buffer, the physical register pool and the scheduler buffers. It also compares the micro-op count with what is left of a per-cycle micro-op budget.

An instruction wider than the budget is still taken when the budget is untouched. Its surplus micro-ops carry over and use up the budget of the cycles that follow. While that surplus is pending, nothing new dispatches.

When an instruction dispatches, the block pulses allocate outputs carrying the amounts consumed. When the head instruction is held back, one saturating stall counter grows, chosen by cause. The handshake on the instruction input is valid/ready. Ready is high only in a cycle in which the head instruction dispatches, so a held-back instruction is simply offered again.

Top module: `dispatch_gate`

## Requirements
- R1: After reset the allocate outputs and all four stall counters are zero, the carry-over is empty and the budget is full. An instruction of exactly DISPATCH_W micro-ops offered in the first cycle dispatches at once.
- R2: An instruction dispatches only if all three resource checks pass:
  - robFree ≥ its micro-op count;
  - regFree ≥ its destination count;
  - schedFree ≥ its scheduler demand.
- R3: At the start of each cycle the budget refills to DISPATCH_W. Pending carry-over is then subtracted from it, up to DISPATCH_W. An instruction passes the width check when no carry-over is left after that subtraction and either its micro-op count ≤ the remaining budget or the remaining budget equals DISPATCH_W.
- R4: An instruction dispatched with more micro-ops than the budget leaves the excess as carry-over. Each later cycle removes up to DISPATCH_W of the carry-over, and no instruction dispatches in a cycle that still has carry-over left after that removal.
- R5: instReady is combinational and is high exactly in a cycle where instValid is high and every check of R2 and R3 passes. A held-back instruction is retried unchanged in later cycles.
- R6: In the cycle after a dispatch, allocValid is 1, and allocRob, allocReg and allocSched equal the dispatched micro-op, destination and scheduler counts. In any other cycle all four outputs are 0.
- R7: Each cycle in which instValid is high and instReady is low adds one to exactly one stall counter, visible after the next edge. The counter is chosen by priority, highest first:
  - robFree too small (stallRobCnt);
  - regFree too small (stallRegCnt);
  - schedFree too small (stallSchedCnt);
  - width check failed (stallWidthCnt).
- R8: Stall counters are CNT_W bits wide and stop at all ones instead of wrapping.
- R9: A cycle with instValid low changes no stall counter, and instReady stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Head instruction present |
| instUops | input | UOP_W | Micro-op count of head instruction |
| instDests | input | DEST_W | Destination registers to rename |
| instSchedNeed | input | SNEED_W | Scheduler entries required |
| instReady | output | 1 | Head instruction dispatched this cycle |
| robFree | input | FREE_W | Free reorder-buffer entries |
| regFree | input | FREE_W | Free physical registers |
| schedFree | input | FREE_W | Free scheduler entries |
| allocValid | output | 1 | Allocation pulse, one cycle after dispatch |
| allocRob | output | UOP_W | Reorder-buffer entries consumed |
| allocReg | output | DEST_W | Physical registers consumed |
| allocSched | output | SNEED_W | Scheduler entries consumed |
| stallRobCnt | output | CNT_W | Stalls caused by a full reorder buffer |
| stallRegCnt | output | CNT_W | Stalls caused by an empty register pool |
| stallSchedCnt | output | CNT_W | Stalls caused by full scheduler buffers |
| stallWidthCnt | output | CNT_W | Stalls caused by the width budget |

## Verification
instReady is combinational, so it is due in the same cycle as the stimulus. The bench checks it 1 ns after driving inputs on the falling edge. The allocate pulse and the stall-counter updates pass through one register, so they are due after the next rising edge. The bench checks them at the following falling edge, before it drives new inputs. Expected values come from a bench model of budget and carry-over arithmetic, stepped once per cycle. A second instance with 3-bit counters shows saturation.

// File: rtl/dispatch_gate_pkg.sv
package dispatch_gate_pkg;

  // Stall causes, listed in priority order (highest first).
  typedef enum logic [1:0] {
    CAUSE_ROB   = 2'd0,
    CAUSE_REG   = 2'd1,
    CAUSE_SCHED = 2'd2,
    CAUSE_WIDTH = 2'd3
  } stall_cause_e;

  localparam int NUM_CAUSES = 4;

  // Strobes from control to datapath.
  typedef struct packed {
    logic         fire;
    logic         stall;
    stall_cause_e cause;
  } gate_strobe_t;

endpackage

// File: rtl/dispatch_gate_ctrl.sv
module dispatch_gate_ctrl
  import dispatch_gate_pkg::*;
#(
  parameter int DISPATCH_W = 4,
  parameter int UOP_W      = 4,
  parameter int DEST_W     = 3,
  parameter int SNEED_W    = 3,
  parameter int FREE_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [UOP_W-1:0]   instUops,
  input  logic [DEST_W-1:0]  instDests,
  input  logic [SNEED_W-1:0] instSchedNeed,
  input  logic [FREE_W-1:0]  robFree,
  input  logic [FREE_W-1:0]  regFree,
  input  logic [FREE_W-1:0]  schedFree,
  input  logic [UOP_W-1:0]   carryQ,
  output logic [UOP_W-1:0]   carryNext,
  output gate_strobe_t       strobe
);

  localparam logic [UOP_W-1:0] FULL_BUDGET = UOP_W'(DISPATCH_W);

  logic [UOP_W-1:0] consume;
  logic [UOP_W-1:0] carryRem;
  logic [UOP_W-1:0] budget;
  logic             budgetOk;
  logic             robOk;
  logic             regOk;
  logic             schedOk;
  logic             fire;

  // Refill the budget, then take pending carry-over out of it.
  always_comb begin
    consume  = (carryQ > FULL_BUDGET) ? FULL_BUDGET : carryQ;
    carryRem = carryQ - consume;
    budget   = FULL_BUDGET - consume;
  end

  always_comb begin
    budgetOk = (carryRem == '0) &&
               ((instUops <= budget) || (budget == FULL_BUDGET));
    robOk    = robFree   >= {{(FREE_W-UOP_W){1'b0}}, instUops};
    regOk    = regFree   >= {{(FREE_W-DEST_W){1'b0}}, instDests};
    schedOk  = schedFree >= {{(FREE_W-SNEED_W){1'b0}}, instSchedNeed};
    fire     = instValid && robOk && regOk && schedOk && budgetOk;
  end

  always_comb begin
    strobe.fire  = fire;
    strobe.stall = instValid && !fire;
    if (!robOk)        strobe.cause = CAUSE_ROB;
    else if (!regOk)   strobe.cause = CAUSE_REG;
    else if (!schedOk) strobe.cause = CAUSE_SCHED;
    else               strobe.cause = CAUSE_WIDTH;
  end

  // Excess micro-ops of a wide instruction become carry-over.
  always_comb begin
    if (fire)
      carryNext = (instUops > budget) ? (instUops - budget) : '0;
    else
      carryNext = carryRem;
  end

  // R4: no dispatch while carry-over outlives this cycle's refill
  a_r4_hold_on_carry: assert property (@(posedge clk) disable iff (!rstN)
    (carryQ > FULL_BUDGET) |-> !strobe.fire);

  // R7: a stall cause of lower priority is never reported over a resource shortage
  a_r7_width_cause_last: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stall && strobe.cause == CAUSE_WIDTH) |-> (robOk && regOk && schedOk));

endmodule

// File: rtl/dispatch_gate_satcnt.sv
module dispatch_gate_satcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX_V = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       count <= '0;
    else if (inc && count != MAX_V)  count <= count + 1'b1;
  end

  // R8: a full counter never wraps
  a_r8_hold_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (count == MAX_V) |=> (count == MAX_V));

  // R7: a counter moves by at most one per cycle
  a_r7_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (count != MAX_V) |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/dispatch_gate_dp.sv
module dispatch_gate_dp
  import dispatch_gate_pkg::*;
#(
  parameter int UOP_W   = 4,
  parameter int DEST_W  = 3,
  parameter int SNEED_W = 3,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  gate_strobe_t       strobe,
  input  logic [UOP_W-1:0]   carryNext,
  input  logic [UOP_W-1:0]   instUops,
  input  logic [DEST_W-1:0]  instDests,
  input  logic [SNEED_W-1:0] instSchedNeed,
  output logic [UOP_W-1:0]   carryQ,
  output logic               allocValid,
  output logic [UOP_W-1:0]   allocRob,
  output logic [DEST_W-1:0]  allocReg,
  output logic [SNEED_W-1:0] allocSched,
  output logic [NUM_CAUSES-1:0][CNT_W-1:0] stallCnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryQ     <= '0;
      allocValid <= 1'b0;
      allocRob   <= '0;
      allocReg   <= '0;
      allocSched <= '0;
    end else begin
      carryQ     <= carryNext;
      allocValid <= strobe.fire;
      allocRob   <= strobe.fire ? instUops      : '0;
      allocReg   <= strobe.fire ? instDests     : '0;
      allocSched <= strobe.fire ? instSchedNeed : '0;
    end
  end

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
    logic bump;
    assign bump = strobe.stall && (strobe.cause == stall_cause_e'(c));
    dispatch_gate_satcnt #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (bump),
      .count (stallCnt[c])
    );
  end

  // R6: allocation amounts are zero outside a pulse
  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !allocValid |-> (allocRob == '0 && allocReg == '0 && allocSched == '0));

endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
  import dispatch_gate_pkg::*;
#(
  parameter int DISPATCH_W = 4,
  parameter int UOP_W      = 4,
  parameter int DEST_W     = 3,
  parameter int SNEED_W    = 3,
  parameter int FREE_W     = 6,
  parameter int CNT_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic [UOP_W-1:0]   instUops,
  input  logic [DEST_W-1:0]  instDests,
  input  logic [SNEED_W-1:0] instSchedNeed,
  output logic               instReady,
  input  logic [FREE_W-1:0]  robFree,
  input  logic [FREE_W-1:0]  regFree,
  input  logic [FREE_W-1:0]  schedFree,
  output logic               allocValid,
  output logic [UOP_W-1:0]   allocRob,
  output logic [DEST_W-1:0]  allocReg,
  output logic [SNEED_W-1:0] allocSched,
  output logic [CNT_W-1:0]   stallRobCnt,
  output logic [CNT_W-1:0]   stallRegCnt,
  output logic [CNT_W-1:0]   stallSchedCnt,
  output logic [CNT_W-1:0]   stallWidthCnt
);

  gate_strobe_t     strobe;
  logic [UOP_W-1:0] carryQ;
  logic [UOP_W-1:0] carryNext;
  logic [NUM_CAUSES-1:0][CNT_W-1:0] stallCnt;

  dispatch_gate_ctrl #(
    .DISPATCH_W (DISPATCH_W),
    .UOP_W      (UOP_W),
    .DEST_W     (DEST_W),
    .SNEED_W    (SNEED_W),
    .FREE_W     (FREE_W)
  ) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .instValid     (instValid),
    .instUops      (instUops),
    .instDests     (instDests),
    .instSchedNeed (instSchedNeed),
    .robFree       (robFree),
    .regFree       (regFree),
    .schedFree     (schedFree),
    .carryQ        (carryQ),
    .carryNext     (carryNext),
    .strobe        (strobe)
  );

  dispatch_gate_dp #(
    .UOP_W   (UOP_W),
    .DEST_W  (DEST_W),
    .SNEED_W (SNEED_W),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .carryNext     (carryNext),
    .instUops      (instUops),
    .instDests     (instDests),
    .instSchedNeed (instSchedNeed),
    .carryQ        (carryQ),
    .allocValid    (allocValid),
    .allocRob      (allocRob),
    .allocReg      (allocReg),
    .allocSched    (allocSched),
    .stallCnt      (stallCnt)
  );

  assign instReady     = strobe.fire;
  assign stallRobCnt   = stallCnt[CAUSE_ROB];
  assign stallRegCnt   = stallCnt[CAUSE_REG];
  assign stallSchedCnt = stallCnt[CAUSE_SCHED];
  assign stallWidthCnt = stallCnt[CAUSE_WIDTH];

  // R2: a dispatch never over-commits any resource pool
  a_r2_rob_room: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> (robFree >= {{(FREE_W-UOP_W){1'b0}}, instUops}));
  a_r2_reg_room: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> (regFree >= {{(FREE_W-DEST_W){1'b0}}, instDests}));
  a_r2_sched_room: assert property (@(posedge clk) disable iff (!rstN)
    instReady |-> (schedFree >= {{(FREE_W-SNEED_W){1'b0}}, instSchedNeed}));

  // R6: allocation amounts match the instruction dispatched one cycle earlier
  a_r6_alloc_match: assert property (@(posedge clk) disable iff (!rstN)
    instReady |=> (allocValid && allocRob == $past(instUops) &&
                   allocReg == $past(instDests)));

  // R7: at most one stall counter changes per cycle
  a_r7_single_cause: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones({stallRobCnt != $past(stallRobCnt),
                          stallRegCnt != $past(stallRegCnt),
                          stallSchedCnt != $past(stallSchedCnt),
                          stallWidthCnt != $past(stallWidthCnt)}) <= 1));

  // R9: no counter moves after an idle cycle
  a_r9_idle_no_count: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> ($stable(stallRobCnt) && $stable(stallRegCnt) &&
                    $stable(stallSchedCnt) && $stable(stallWidthCnt)));

endmodule

// File: tb/dispatch_gate_tb_top.sv
`timescale 1ns/1ps
module dispatch_gate_tb_top;

  localparam int W     = 4;
  localparam int SATW  = 3;
  localparam int SATMX = 7;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [3:0] instUops = '0;
  logic [2:0] instDests = '0;
  logic [2:0] instSchedNeed = '0;
  logic [5:0] robFree = '0, regFree = '0, schedFree = '0;

  logic        instReady, allocValid;
  logic [3:0]  allocRob;
  logic [2:0]  allocReg, allocSched;
  logic [31:0] cRob, cReg, cSch, cWid;

  logic        satReady, satAllocValid;
  logic [3:0]  satAllocRob;
  logic [2:0]  satAllocReg, satAllocSched;
  logic [SATW-1:0] sRob, sReg, sSch, sWid;

  always #2 clk = ~clk;

  dispatch_gate #(.DISPATCH_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instUops(instUops),
    .instDests(instDests), .instSchedNeed(instSchedNeed), .instReady(instReady),
    .robFree(robFree), .regFree(regFree), .schedFree(schedFree),
    .allocValid(allocValid), .allocRob(allocRob), .allocReg(allocReg),
    .allocSched(allocSched), .stallRobCnt(cRob), .stallRegCnt(cReg),
    .stallSchedCnt(cSch), .stallWidthCnt(cWid));

  dispatch_gate #(.DISPATCH_W(W), .CNT_W(SATW)) dutSat_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instUops(instUops),
    .instDests(instDests), .instSchedNeed(instSchedNeed), .instReady(satReady),
    .robFree(robFree), .regFree(regFree), .schedFree(schedFree),
    .allocValid(satAllocValid), .allocRob(satAllocRob), .allocReg(satAllocReg),
    .allocSched(satAllocSched), .stallRobCnt(sRob), .stallRegCnt(sReg),
    .stallSchedCnt(sSch), .stallWidthCnt(sWid));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state
  int carry = 0;
  int cnt [4] = '{0, 0, 0, 0};
  bit expAv = 1'b0;
  int expAr = 0, expAg = 0, expAs = 0;
  bit lastFire = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int satv(input int v);
    return (v > SATMX) ? SATMX : v;
  endfunction

  task automatic checkRegs();
    chk(allocValid == expAv, "R6 allocValid", allocValid, expAv);
    chk(allocRob == expAr, "R6 allocRob", allocRob, expAr);
    chk(allocReg == expAg, "R6 allocReg", allocReg, expAg);
    chk(allocSched == expAs, "R6 allocSched", allocSched, expAs);
    chk(cRob == cnt[0], "R7 stallRob", cRob, cnt[0]);
    chk(cReg == cnt[1], "R7 stallReg", cReg, cnt[1]);
    chk(cSch == cnt[2], "R7 stallSched", cSch, cnt[2]);
    chk(cWid == cnt[3], "R7 stallWidth", cWid, cnt[3]);
    chk(sRob == satv(cnt[0]), "R8 satRob", sRob, satv(cnt[0]));
    chk(sReg == satv(cnt[1]), "R8 satReg", sReg, satv(cnt[1]));
    chk(sSch == satv(cnt[2]), "R8 satSched", sSch, satv(cnt[2]));
    chk(sWid == satv(cnt[3]), "R8 satWidth", sWid, satv(cnt[3]));
  endtask

  // One cycle: check registered results of the previous cycle, drive, check ready.
  task automatic step(input bit v, input int u, input int d, input int s,
                      input int rf, input int gf, input int sf, input string req);
    int consume, rem, budget;
    bit wOk, rOk, gOk, sOk, fire;
    @(negedge clk);
    checkRegs();
    instValid = v; instUops = 4'(u); instDests = 3'(d); instSchedNeed = 3'(s);
    robFree = 6'(rf); regFree = 6'(gf); schedFree = 6'(sf);
    #1;
    consume = (carry > W) ? W : carry;
    rem     = carry - consume;
    budget  = W - consume;
    wOk  = (rem == 0) && ((u <= budget) || (budget == W));
    rOk  = rf >= u;
    gOk  = gf >= d;
    sOk  = sf >= s;
    fire = v && wOk && rOk && gOk && sOk;
    chk(instReady == fire, req, instReady, fire);
    chk(satReady == fire, req, satReady, fire);
    if (fire) carry = (u > budget) ? (u - budget) : 0;
    else      carry = rem;
    expAv = fire;
    expAr = fire ? u : 0;
    expAg = fire ? d : 0;
    expAs = fire ? s : 0;
    if (v && !fire) begin
      if (!rOk)      cnt[0]++;
      else if (!gOk) cnt[1]++;
      else if (!sOk) cnt[2]++;
      else           cnt[3]++;
    end
    lastFire = fire;
  endtask

  // Offer one instruction until it dispatches (in-order retry).
  task automatic sendUntil(input int u, input int d, input int s, input string req);
    for (int t = 0; t < 8; t++) begin
      step(1'b1, u, d, s, 40, 7, 7, req);
      if (lastFire) break;
    end
    chk(lastFire == 1'b1, {req, " eventual dispatch"}, lastFire, 1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkRegs();
    chk(instReady == 1'b0, "R1 ready in reset", instReady, 0);
    rstN = 1'b1;

    // R1: full-width instruction goes at once
    step(1'b1, W, 2, 2, 40, 7, 7, "R1 first dispatch");

    // R9: idle cycles with empty pools count nothing
    step(1'b0, 5, 7, 7, 0, 0, 0, "R9 idle ready low");
    step(1'b0, 15, 7, 7, 0, 0, 0, "R9 idle ready low");

    // R3/R4/R5: sweep a wide-then-narrow pair
    for (int a = 1; a <= 11; a++) begin
      for (int b = 1; b <= 5; b++) begin
        sendUntil(a, 1, 1, (a > W) ? "R4 wide instruction" : "R3 narrow instruction");
        sendUntil(b, 2, 1, "R5 younger instruction retried");
        step(1'b0, 0, 0, 0, 40, 7, 7, "R9 drain");
        step(1'b0, 0, 0, 0, 40, 7, 7, "R9 drain");
        step(1'b0, 0, 0, 0, 40, 7, 7, "R9 drain");
      end
    end

    // R2/R7/R8: resource sweep, carry stays empty (3 uops < width)
    for (int rf = 0; rf <= 5; rf++)
      for (int gf = 0; gf <= 3; gf++)
        for (int sf = 0; sf <= 3; sf++)
          step(1'b1, 3, 2, 2, rf, gf, sf, "R2 resource gate");

    // R7: resource shortage outranks a pending carry-over
    step(1'b1, 11, 1, 1, 40, 7, 7, "R4 wide dispatch");
    step(1'b1, 2, 1, 1, 0, 7, 7, "R7 rob over width");
    step(1'b1, 2, 1, 1, 40, 7, 7, "R7 width stall");
    step(1'b1, 2, 1, 1, 40, 7, 7, "R3 budget after carry");
    step(1'b0, 0, 0, 0, 40, 7, 7, "R9 drain");

    @(negedge clk);
    checkRegs();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule